// File: doc/BRIEF.md
# Indexed Audio Codec Control Registers

This block is the byte-wide host register front end of an audio codec. The host sees four direct ports. Port 0 holds an index pointer. Port 1 reads or writes the indirect control register that the pointer selects. Port 2 is the interrupt status. Port 3 is a programmed-I/O data slot that stays inert. Behind the pointer sits a bank of 32 indirect byte registers. Only the lower 16 can be reached until the extended mode bit is set.

Each indirect register follows its own write rule. Some registers are reserved, one is read-only, some are only partly writable, and the sample format register is gated by two mode-change-enable flags. A completion event from the sample engine raises the interrupt. The host clears it, either through the status port or by clearing the pending flag in the alternate status register. The current format and configuration bytes and the extended mode flag are brought out for the rest of the codec.

Top module: `audio_ctl_regs`

## Requirements
- R1: After reset the index pointer reads 0x40. Indirect registers 2–5 and 18–19 hold 0x88, 6–7 hold 0x80, 9 holds 0x08, 12 holds 0x8A, 25–26 hold 0xA0, and every other register holds 0x00.
- R2: A port 0 write stores bits 6:0 of the byte. Bit 7 is dropped, so a port 0 read returns 0 in bit 7. Bit 6 of the pointer is the mode-change-enable flag (MCE).
- R3: The indirect address is pointer bits 3:0 while bit 6 of register 12 is 0. It is pointer bits 4:0 while that bit is 1, and `extMode` shows that bit.
- R4: A write to register 8 stores the whole byte when MCE is 1. When MCE is 0 but bit 4 of register 24 is 1, it stores bits 7:4 and keeps the old bits 3:0. When both flags are 0, the write is dropped.
- R5: Writes to registers 11, 22, 27 and 29 change nothing. A write to register 12 changes only its bit 6. A write to register 9 stores the byte with bit 5 forced to 0.
- R6: Any write to port 2 clears the interrupt flag and clears bits 6:4 of register 24.
- R7: A write to register 24 that takes bit 4 from 1 to 0 clears the interrupt flag. A write that leaves bit 4 set does not.
- R8: A `blockDone` pulse sets the interrupt flag and bit 4 of register 24. When it lands in the same cycle as a clearing write, the set wins.
- R9: When a port 0 write takes MCE from 0 to 1 while register 9 bits 4:3 are not both 0, the next CAL_COUNT reads of register 11 (default 1) return bit 5 as 1. Later reads return it as 0. Without that rising edge and condition, bit 5 reads 0.
- R10: A port 3 read returns 0x00, and port 3 writes have no effect. A port 2 read returns the interrupt flag in bit 0 and 0 in bits 7:1.
- R11: Read data appears on `busRdata` one cycle after the read strobe and holds until the next read. `irq` is a level equal to the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Single-cycle access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Direct port: 0 index, 1 data, 2 status, 3 PIO |
| busWdata | input | 8 | Write byte |
| busRdata | output | 8 | Registered read byte |
| blockDone | input | 1 | Playback block completion pulse |
| irq | output | 1 | Interrupt level |
| fmtReg | output | 8 | Current sample format register (8) |
| cfgReg | output | 8 | Current interface configuration register (9) |
| extMode | output | 1 | Extended 32-register addressing active |

## Verification
The interrupt flag has a set source and two clear sources, and these can fall in the same cycle. A `blockDone` pulse can coincide with a status port write, or with a register 24 write that drops the pending bit. The bench provokes both collisions on purpose, with one strobe in each direction in a single cycle. It judges them against a behavioural model in which the set is applied after the clear, so `irq` must stay high and register 24 must read back with bit 4 set.

// File: rtl/actl_pkg.sv
package actl_pkg;
  localparam int REG_NUM = 32;
  localparam int IDX_W = $clog2(REG_NUM);

  localparam logic [IDX_W-1:0] ADDR_FORMAT  = IDX_W'(8);
  localparam logic [IDX_W-1:0] ADDR_CONFIG  = IDX_W'(9);
  localparam logic [IDX_W-1:0] ADDR_INIT    = IDX_W'(11);
  localparam logic [IDX_W-1:0] ADDR_MODE    = IDX_W'(12);
  localparam logic [IDX_W-1:0] ADDR_RSV_A   = IDX_W'(22);
  localparam logic [IDX_W-1:0] ADDR_ALTSTAT = IDX_W'(24);
  localparam logic [IDX_W-1:0] ADDR_RSV_B   = IDX_W'(27);
  localparam logic [IDX_W-1:0] ADDR_RSV_C   = IDX_W'(29);

  typedef enum logic [1:0] {
    PORT_INDEX  = 2'd0,
    PORT_DATA   = 2'd1,
    PORT_STATUS = 2'd2,
    PORT_PIO    = 2'd3
  } actl_port_e;

  typedef struct packed {
    logic             regWr;
    logic             rdEn;
    logic             statClr;
    logic             mceOn;
    logic             calHit;
    actl_port_e       rdPort;
    logic [IDX_W-1:0] regAddr;
    logic [6:0]       idxVal;
  } actl_strobe_t;

  function automatic logic [7:0] resetValue(input int i);
    case (i)
      2, 3, 4, 5, 18, 19: resetValue = 8'h88;
      6, 7:               resetValue = 8'h80;
      9:                  resetValue = 8'h08;
      12:                 resetValue = 8'h8A;
      25, 26:             resetValue = 8'hA0;
      default:            resetValue = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/actl_control.sv
module actl_control
  import actl_pkg::*;
#(
  parameter int CAL_COUNT = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busSel,
  input  logic         busWr,
  input  logic [1:0]   busAddr,
  input  logic [6:0]   busWdata,
  input  logic         extMode,
  input  logic [1:0]   cfgCalBits,
  output actl_strobe_t stb
);
  localparam int CAL_W = $clog2(CAL_COUNT + 1);

  logic [6:0]       idxReg;
  logic [CAL_W-1:0] calCnt;
  logic             wrAcc, rdAcc, calHit;
  actl_port_e       port;
  logic [IDX_W-1:0] regAddr;

  assign port    = actl_port_e'(busAddr);
  assign wrAcc   = busSel && busWr;
  assign rdAcc   = busSel && !busWr;
  assign regAddr = extMode ? idxReg[IDX_W-1:0] : {1'b0, idxReg[IDX_W-2:0]};
  assign calHit  = rdAcc && (port == PORT_DATA) && (regAddr == ADDR_INIT) && (calCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxReg <= 7'h40;
      calCnt <= '0;
    end else if (wrAcc && port == PORT_INDEX) begin
      if (!idxReg[6] && busWdata[6] && (cfgCalBits != 2'b00))
        calCnt <= CAL_W'(CAL_COUNT);
      idxReg <= busWdata;
    end else if (calHit) begin
      calCnt <= calCnt - 1'b1;
    end
  end

  always_comb begin
    stb.regWr   = wrAcc && (port == PORT_DATA);
    stb.statClr = wrAcc && (port == PORT_STATUS);
    stb.rdEn    = rdAcc;
    stb.rdPort  = port;
    stb.mceOn   = idxReg[6];
    stb.calHit  = calHit;
    stb.regAddr = regAddr;
    stb.idxVal  = idxReg;
  end
endmodule

// File: rtl/actl_datapath.sv
module actl_datapath
  import actl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  actl_strobe_t stb,
  input  logic [7:0]   wdata,
  input  logic         blockDone,
  output logic [7:0]   rdata,
  output logic         irq,
  output logic [7:0]   fmtReg,
  output logic [7:0]   cfgReg,
  output logic         extMode
);
  logic [7:0] regBank [REG_NUM];
  logic       intFlag;
  logic       piClear;

  assign piClear = stb.regWr && (stb.regAddr == ADDR_ALTSTAT) &&
                   regBank[ADDR_ALTSTAT][4] && !wdata[4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_NUM; i++) regBank[i] <= resetValue(i);
    end else begin
      if (stb.regWr) begin
        case (stb.regAddr)
          ADDR_INIT, ADDR_RSV_A, ADDR_RSV_B, ADDR_RSV_C: ;
          ADDR_MODE:   regBank[ADDR_MODE][6] <= wdata[6];
          ADDR_CONFIG: regBank[ADDR_CONFIG] <= {wdata[7:6], 1'b0, wdata[4:0]};
          ADDR_FORMAT: begin
            if (stb.mceOn)
              regBank[ADDR_FORMAT] <= wdata;
            else if (regBank[ADDR_ALTSTAT][4])
              regBank[ADDR_FORMAT] <= {wdata[7:4], regBank[ADDR_FORMAT][3:0]};
          end
          default: regBank[stb.regAddr] <= wdata;
        endcase
      end
      if (stb.statClr) regBank[ADDR_ALTSTAT][6:4] <= 3'b000;
      if (blockDone)   regBank[ADDR_ALTSTAT][4] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intFlag <= 1'b0;
    end else if (blockDone) begin
      intFlag <= 1'b1;
    end else if (stb.statClr || piClear) begin
      intFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdata <= 8'h00;
    end else if (stb.rdEn) begin
      case (stb.rdPort)
        PORT_INDEX:  rdata <= {1'b0, stb.idxVal};
        PORT_DATA:   rdata <= regBank[stb.regAddr] | {2'b00, stb.calHit, 5'b00000};
        PORT_STATUS: rdata <= {7'b0000000, intFlag};
        default:     rdata <= 8'h00;
      endcase
    end
  end

  assign irq     = intFlag;
  assign fmtReg  = regBank[ADDR_FORMAT];
  assign cfgReg  = regBank[ADDR_CONFIG];
  assign extMode = regBank[ADDR_MODE][6];
endmodule

// File: rtl/audio_ctl_regs.sv
module audio_ctl_regs
  import actl_pkg::*;
#(
  parameter int CAL_COUNT = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       blockDone,
  output logic       irq,
  output logic [7:0] fmtReg,
  output logic [7:0] cfgReg,
  output logic       extMode
);
  actl_strobe_t stb;

  actl_control #(.CAL_COUNT(CAL_COUNT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busWdata   (busWdata[6:0]),
    .extMode    (extMode),
    .cfgCalBits (cfgReg[4:3]),
    .stb        (stb)
  );

  actl_datapath u_data (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wdata     (busWdata),
    .blockDone (blockDone),
    .rdata     (busRdata),
    .irq       (irq),
    .fmtReg    (fmtReg),
    .cfgReg    (cfgReg),
    .extMode   (extMode)
  );
endmodule

// File: rtl/audio_ctl_regs_checks.sv
module audio_ctl_regs_checks (
  input logic       clk,
  input logic       rstN,
  input logic       busSel,
  input logic       busWr,
  input logic [1:0] busAddr,
  input logic [7:0] busWdata,
  input logic [7:0] busRdata,
  input logic       blockDone,
  input logic       irq,
  input logic [7:0] fmtReg,
  input logic [7:0] cfgReg,
  input logic       extMode
);
  AST_STATUS_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == 2'd2 && !blockDone) |=> !irq); // R6
  AST_DONE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |=> irq); // R8
  AST_IRQ_ONLY_FROM_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(blockDone)); // R8
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && !busWr) |=> $stable(busRdata)); // R11
  AST_INDEX_MSB_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == 2'd0) |=> !busRdata[7]); // R2
  AST_PIO_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == 2'd3) |=> busRdata == 8'h00); // R10
  AST_STATUS_READ_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == 2'd2) |=> busRdata == {7'b0000000, $past(irq)}); // R10
  AST_CFG_BIT5_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !cfgReg[5]); // R5
  AST_EXTMODE_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWr) |=> $stable(extMode)); // R3
endmodule

bind audio_ctl_regs audio_ctl_regs_checks u_checks (.*);

// File: tb/audio_ctl_regs_test.sv
module audio_ctl_regs_test;
  logic       clk = 1'b0;
  logic       rstN, busSel, busWr, blockDone;
  logic [1:0] busAddr;
  logic [7:0] busWdata;
  logic [7:0] busRdata, fmtReg, cfgReg;
  logic       irq, extMode;

  always #2 clk = ~clk;

  audio_ctl_regs uut (.*);

  localparam int CAL = 1;
  int errors = 0;
  int checks = 0;
  bit modelOn = 1'b0;
  bit finished = 1'b0;
  int mRegs [32];
  int mIdx, mInt, mCal, mRd;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void modelReset();
    for (int i = 0; i < 32; i++) mRegs[i] = 0;
    for (int i = 2; i <= 5; i++) mRegs[i] = 'h88;
    mRegs[18] = 'h88; mRegs[19] = 'h88;
    mRegs[6] = 'h80;  mRegs[7] = 'h80;
    mRegs[9] = 'h08;  mRegs[12] = 'h8A;
    mRegs[25] = 'hA0; mRegs[26] = 'hA0;
    mIdx = 'h40; mInt = 0; mCal = 0; mRd = 0;
  endfunction

  function automatic void modelStep(input bit s, input bit w, input int a, input int d, input bit dn);
    int ia;
    ia = (mRegs[12] & 'h40) ? (mIdx & 31) : (mIdx & 15);
    if (s && !w) begin
      case (a)
        0: mRd = mIdx;
        1: begin
          mRd = mRegs[ia];
          if (ia == 11 && mCal > 0) begin mRd = mRd | 'h20; mCal--; end
        end
        2: mRd = mInt;
        default: mRd = 0;
      endcase
    end
    if (s && w) begin
      case (a)
        0: begin
          if (!(mIdx & 'h40) && (d & 'h40) && (mRegs[9] & 'h18)) mCal = CAL;
          mIdx = d & 'h7F;
        end
        1: begin
          if (ia == 11 || ia == 22 || ia == 27 || ia == 29) ;
          else if (ia == 12) mRegs[12] = (mRegs[12] & 'hBF) | (d & 'h40);
          else if (ia == 9) mRegs[9] = d & 'hDF;
          else if (ia == 8) begin
            if (mIdx & 'h40) mRegs[8] = d;
            else if (mRegs[24] & 'h10) mRegs[8] = (d & 'hF0) | (mRegs[8] & 'h0F);
          end else if (ia == 24) begin
            if ((mRegs[24] & 'h10) && !(d & 'h10)) mInt = 0;
            mRegs[24] = d;
          end else mRegs[ia] = d;
        end
        2: begin mInt = 0; mRegs[24] = mRegs[24] & 'h8F; end
        default: ;
      endcase
    end
    if (dn) begin mInt = 1; mRegs[24] = mRegs[24] | 'h10; end
  endfunction

  always @(negedge clk) begin
    if (modelOn && !finished) begin
      check(busRdata == mRd[7:0], "R11 model rdata", busRdata, mRd);
      check(irq == mInt[0], "R11 model irq", irq, mInt);
    end
  end

  task automatic step(input bit s, input bit w, input logic [1:0] a, input logic [7:0] d, input bit dn);
    @(negedge clk);
    busSel = s; busWr = w; busAddr = a; busWdata = d; blockDone = dn;
    @(posedge clk);
    #1;
    modelStep(s, w, a, d, dn);
    busSel = 1'b0; busWr = 1'b0; blockDone = 1'b0;
  endtask

  task automatic wrPort(input logic [1:0] a, input logic [7:0] d);
    step(1'b1, 1'b1, a, d, 1'b0);
  endtask

  task automatic expectRd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    step(1'b1, 1'b0, a, 8'h00, 1'b0);
    @(negedge clk);
    check(busRdata == exp, tag, busRdata, exp);
  endtask

  task automatic regRead(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    wrPort(2'd0, idx);
    expectRd(2'd1, exp, tag);
  endtask

  task automatic regWrite(input logic [7:0] idx, input logic [7:0] d);
    wrPort(2'd0, idx);
    wrPort(2'd1, d);
  endtask

  task automatic pulseDone();
    step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busSel = 1'b0; busWr = 1'b0; busAddr = 2'd0; busWdata = 8'h00; blockDone = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
    modelOn = 1'b1;

    // R1 reset state
    check(irq == 1'b0, "R1 irq reset", irq, 0);
    expectRd(2'd0, 8'h40, "R1 index reset");
    regRead(8'h42, 8'h88, "R1 reg2");
    regRead(8'h46, 8'h80, "R1 reg6");
    regRead(8'h49, 8'h08, "R1 reg9");
    regRead(8'h4C, 8'h8A, "R1 reg12");
    regRead(8'h40, 8'h00, "R1 reg0");

    // R2 index bit 7 dropped
    wrPort(2'd0, 8'hC3);
    expectRd(2'd0, 8'h43, "R2 index msb");

    // R3 narrow then wide addressing
    regRead(8'h59, 8'h08, "R3 narrow wraps to reg9");
    regWrite(8'h4C, 8'hFF);
    expectRd(2'd1, 8'hCA, "R5 reg12 only bit6");
    @(negedge clk);
    check(extMode == 1'b1, "R3 extMode", extMode, 1);
    regRead(8'h59, 8'hA0, "R3 wide reg25");
    regRead(8'h52, 8'h88, "R3 wide reg18");

    // R5 write rules
    regWrite(8'h56, 8'h55);
    expectRd(2'd1, 8'h00, "R5 reserved22");
    regWrite(8'h5B, 8'h55);
    expectRd(2'd1, 8'h00, "R5 reserved27");
    regWrite(8'h4B, 8'hFF);
    expectRd(2'd1, 8'h00, "R5 readonly11");
    regWrite(8'h49, 8'hFF);
    expectRd(2'd1, 8'hDF, "R5 reg9 bit5");

    // R9 calibration flag
    wrPort(2'd0, 8'h0B);
    wrPort(2'd0, 8'h4B);
    expectRd(2'd1, 8'h20, "R9 first read");
    expectRd(2'd1, 8'h00, "R9 expired");
    regWrite(8'h49, 8'h01);
    wrPort(2'd0, 8'h0B);
    wrPort(2'd0, 8'h4B);
    expectRd(2'd1, 8'h00, "R9 not armed");

    // R4 format gating
    regWrite(8'h48, 8'h5A);
    expectRd(2'd1, 8'h5A, "R4 mce write");
    regWrite(8'h08, 8'h33);
    expectRd(2'd1, 8'h5A, "R4 dropped");
    regWrite(8'h18, 8'h10);
    regWrite(8'h08, 8'hC7);
    expectRd(2'd1, 8'hCA, "R4 pmce keeps low");
    @(negedge clk);
    check(fmtReg == 8'hCA, "R4 fmtReg", fmtReg, 8'hCA);

    // R7 pending clear through reg24
    pulseDone();
    @(negedge clk);
    check(irq == 1'b1, "R8 done sets irq", irq, 1);
    regWrite(8'h18, 8'h10);
    @(negedge clk);
    check(irq == 1'b1, "R7 pi kept", irq, 1);
    regWrite(8'h18, 8'h00);
    @(negedge clk);
    check(irq == 1'b0, "R7 pi cleared", irq, 0);

    // R6 status port clear
    regWrite(8'h18, 8'h7F);
    pulseDone();
    wrPort(2'd2, 8'h00);
    @(negedge clk);
    check(irq == 1'b0, "R6 status clear", irq, 0);
    regRead(8'h18, 8'h0F, "R6 reg24 bits");

    // R8 collisions
    step(1'b1, 1'b1, 2'd2, 8'h00, 1'b1);
    @(negedge clk);
    check(irq == 1'b1, "R8 status collision", irq, 1);
    regRead(8'h18, 8'h1F, "R8 pi after collision");
    step(1'b1, 1'b1, 2'd1, 8'h0F, 1'b1);
    @(negedge clk);
    check(irq == 1'b1, "R8 reg24 collision", irq, 1);

    // R10 PIO and status ports
    expectRd(2'd3, 8'h00, "R10 pio read");
    wrPort(2'd3, 8'h99);
    expectRd(2'd3, 8'h00, "R10 pio write ignored");
    expectRd(2'd2, 8'h01, "R10 status read");

    // R11 read data holds
    repeat (3) @(negedge clk);
    check(busRdata == 8'h01, "R11 hold", busRdata, 8'h01);

    @(negedge clk);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule